// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to sixteen peripheral interrupt lines and presents one prioritized request to a processor. Each line has an 8-bit control/status word. That word sets the line's priority level, its enable, its trigger mode (level or edge) and its active polarity. One bit of the word reports whether the line is currently requesting.

A master enable gates all requests. A processor mask level then filters them, so that only levels strictly above the mask reach the processor. The block continuously drives the level of the best request. When the processor runs an acknowledge cycle, the block returns an 8-bit vector equal to a shared base plus the 4-bit index of the winning source.

Source inputs are asynchronous and pass through a two-stage synchronizer. Edge-triggered sources latch a pending flag that software clears through the control word. Level-triggered sources request only while their input is in the active state.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, irq_level is 0, vec_valid is 0, and every control word reads 0x00.
- R2: A write stores bits 7, 6, 4 and 2:0 of the control word for the source chosen by cfg_sel. A read returns those stored bits, with bit 3 reading 0 and bit 5 giving the request status.
- R3: In level mode (bit 6 = 0), the source requests while its synchronized input equals 1 when bit 7 = 0, or equals 0 when bit 7 = 1. Its status bit 5 drops when the input leaves the active state.
- R4: In edge mode (bit 6 = 1), a 0-to-1 transition (bit 7 = 0) or a 1-to-0 transition (bit 7 = 1) sets a pending flag. The flag stays set after the input returns to its old value.
- R5: A write with bit 3 = 1 clears the pending flag of the addressed source. A write with bit 3 = 0 leaves that flag unchanged.
- R6: A source with enable bit 4 = 0, or with level bits 2:0 = 0, never raises irq_level.
- R7: While master_en is 0, irq_level is 0 and an acknowledge returns no vector.
- R8: irq_level equals the highest level among enabled, requesting sources whose level is strictly above mask_lvl, or 0 when there is none.
- R9: Among qualifying sources at the same level, the source with the higher index wins.
- R10: In the cycle after iack is sampled high with a request present, vec_valid is 1 and vec_out = (vec_base + winner index) mod 256. An acknowledge with no request leaves vec_valid at 0, and vec_valid lasts one cycle per single-cycle acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 16 | Asynchronous peripheral interrupt lines |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 4 | Source index for control word read and write |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word and status of the selected source |
| master_en | input | 1 | Master interrupt enable |
| mask_lvl | input | 3 | Processor mask level |
| vec_base | input | 8 | Vector base |
| irq_level | output | 3 | Level of the winning request, 0 for none |
| iack | input | 1 | Acknowledge strobe |
| vec_out | output | 8 | Acknowledged vector |
| vec_valid | output | 1 | vec_out is valid this cycle |

## Verification
A control word write takes effect one edge later. The mask, base and master enable act on irq_level combinationally. A level input reaches irq_level after two edges of synchronization, and an edge-mode pending flag is set on the third edge. The vector appears one edge after iack is sampled. The bench therefore drives on falling edges and waits four full cycles after any source input change before it compares. It checks config effects at the following falling edge, and samples the vector at the falling edge right after the acknowledge edge and again one cycle later to see it drop.

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NSRC = 16,
  parameter int SW   = $clog2(NSRC),
  parameter int VW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_sel,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic            master_en,
  input  logic [2:0]      mask_lvl,
  input  logic [VW-1:0]   vec_base,
  output logic [2:0]      irq_level,
  input  logic            iack,
  output logic [VW-1:0]   vec_out,
  output logic            vec_valid
);

  logic [NSRC-1:0] sy1, sy2, sy3, pend, trig, pol, ien, ev, hit;
  logic [2:0]      lvl [NSRC];
  logic [2:0]      best_l;
  logic [SW-1:0]   best_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= src_in; sy2 <= sy1; sy3 <= sy2;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic wr_me;
    assign wr_me  = cfg_we && (cfg_sel == SW'(i));
    assign ev[i]  = trig[i] && (pol[i] ? (sy3[i] && !sy2[i]) : (!sy3[i] && sy2[i]));
    assign hit[i] = trig[i] ? pend[i] : (sy2[i] ^ pol[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl[i] <= '0; ien[i] <= 1'b0; trig[i] <= 1'b0; pol[i] <= 1'b0; pend[i] <= 1'b0;
      end else begin
        if (wr_me) begin
          lvl[i]  <= cfg_wdata[2:0];
          ien[i]  <= cfg_wdata[4];
          trig[i] <= cfg_wdata[6];
          pol[i]  <= cfg_wdata[7];
        end
        if (ev[i])                       pend[i] <= 1'b1;
        else if (wr_me && cfg_wdata[3])  pend[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    best_l = '0;
    best_i = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (master_en && ien[i] && hit[i] && lvl[i] > mask_lvl && lvl[i] >= best_l) begin
        best_l = lvl[i];
        best_i = SW'(i);
      end
    end
  end

  assign irq_level = best_l;
  assign cfg_rdata = {pol[cfg_sel], trig[cfg_sel], hit[cfg_sel], ien[cfg_sel], 1'b0, lvl[cfg_sel]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= iack && (best_l != 3'd0);
      if (iack && best_l != 3'd0) vec_out <= vec_base + VW'(best_i);
    end
  end

  // R8
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd0) |-> (irq_level > mask_lvl));

  // R7
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (irq_level == 3'd0));

  // R10
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(iack) && $past(irq_level) != 3'd0));

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[3] && !ev[cfg_sel]) |=> !pend[$past(cfg_sel)]);

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[cfg_sel] && !(cfg_we && cfg_wdata[3])) |=> pend[$past(cfg_sel)]);

endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
  logic clk = 0, rst_n = 0;
  logic [15:0] src_in = '0;
  logic cfg_we = 0, master_en = 0, iack = 0;
  logic [3:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0, vec_base = '0;
  logic [2:0] mask_lvl = '0;
  logic [7:0] cfg_rdata, vec_out;
  logic [2:0] irq_level;
  logic vec_valid;

  int checks = 0, errors = 0;
  logic [7:0] cfg_m [16];
  logic [15:0] pend_m = '0, in_m = '0;

  prio_vec_intc dut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .master_en(master_en), .mask_lvl(mask_lvl), .vec_base(vec_base),
    .irq_level(irq_level), .iack(iack), .vec_out(vec_out), .vec_valid(vec_valid));

  always #4 clk = ~clk;

  function automatic logic hit_m(int i);
    return cfg_m[i][6] ? pend_m[i] : (in_m[i] ^ cfg_m[i][7]);
  endfunction

  function automatic logic [6:0] best_m();
    logic [2:0] bl = 0; logic [3:0] bi = 0;
    for (int i = 0; i < 16; i++)
      if (master_en && cfg_m[i][4] && hit_m(i) && cfg_m[i][2:0] > mask_lvl && cfg_m[i][2:0] >= bl) begin
        bl = cfg_m[i][2:0]; bi = 4'(i);
      end
    return {bl, bi};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = 4'(sel); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    cfg_m[sel] = d & 8'hD7;
    if (d[3]) pend_m[sel] = 0;
  endtask

  task automatic set_in(logic [15:0] v);
    @(negedge clk);
    for (int i = 0; i < 16; i++)
      if (cfg_m[i][6] && (cfg_m[i][7] ? (in_m[i] && !v[i]) : (!in_m[i] && v[i]))) pend_m[i] = 1;
    src_in = v; in_m = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_lvl(string tag);
    logic [6:0] b = best_m();
    chk(tag, irq_level, b[6:4]);
  endtask

  task automatic chk_rd(string tag, int sel);
    cfg_sel = 4'(sel); #1;
    chk(tag, cfg_rdata, {cfg_m[sel][7:6], hit_m(sel), cfg_m[sel][4], 1'b0, cfg_m[sel][2:0]});
  endtask

  task automatic chk_ack(string tag);
    logic [6:0] b = best_m();
    @(negedge clk); iack = 1;
    @(negedge clk); iack = 0;
    chk(tag, vec_valid, b[6:4] != 0);
    if (b[6:4] != 0) chk(tag, vec_out, 8'(vec_base + 8'(b[3:0])));
    @(negedge clk);
    chk(tag, vec_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hang expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16; i++) cfg_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", irq_level, 0);
    chk("R1", vec_valid, 0);
    chk_rd("R1", 5);
    master_en = 1;
    // R2 write and read back, bit3 reads 0
    wr(3, 8'hFF);
    chk_rd("R2", 3);
    wr(3, 8'h00);
    // R3 level mode, low-active
    wr(2, 8'h95);
    chk_rd("R3", 2); chk_lvl("R3");
    set_in(16'h0004);
    chk_rd("R3", 2); chk_lvl("R3");
    set_in(16'h0000);
    // R4 edge mode rising, held after release
    wr(7, 8'h53);
    set_in(16'h0080); set_in(16'h0000);
    chk_rd("R4", 7); chk_lvl("R4");
    // R5 bit3=0 keeps, bit3=1 clears
    wr(7, 8'h53); chk_rd("R5", 7);
    wr(7, 8'h5B); chk_rd("R5", 7); chk_lvl("R5");
    // R4 falling edge
    wr(8, 8'hD4);
    set_in(16'h0100); set_in(16'h0000);
    chk_rd("R4", 8);
    // R6 disabled and level-0 sources
    wr(8, 8'hC4); wr(2, 8'h85); wr(9, 8'h10);
    set_in(16'h0200); chk_lvl("R6");
    // R7 master off
    wr(2, 8'h95); master_en = 0; @(negedge clk); chk_lvl("R7"); chk_ack("R7");
    master_en = 1;
    // R8 mask
    mask_lvl = 5; @(negedge clk); chk_lvl("R8");
    mask_lvl = 4; @(negedge clk); chk_lvl("R8");
    // R9 tie at level 5 between 2 and 11
    wr(11, 8'h15); set_in(16'h0800); mask_lvl = 0;
    @(negedge clk); chk_lvl("R9"); chk_ack("R9");
    // R10 wraparound base
    vec_base = 8'hFE; chk_ack("R10");
    set_in(16'h0004); wr(11, 8'h00); wr(8, 8'h08); chk_ack("R10");
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 2) wr($urandom % 16, 8'($urandom));
      if ($urandom % 2) set_in(16'($urandom));
      master_en = ($urandom % 8) != 0;
      mask_lvl = 3'($urandom);
      vec_base = 8'($urandom);
      @(negedge clk);
      chk_lvl("R8");
      chk_rd("R2", $urandom % 16);
      if ($urandom % 2) chk_ack("R10");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule